// File: doc/BRIEF.md
# Parameterized Combinational Binary-to-BCD Converter

This block turns an unsigned binary word of width N into packed binary-coded decimal. It needs no clock: the result follows the input through a cascade of shift-and-add-3 stages. Each stage pulls in one more input bit, starting from the most significant one. Before that bit is shifted in, any decimal digit that has reached 5 or more is raised by 3.

The cascade is built from N at elaboration time. The first three input bits need no correction, so they seed the chain directly, and N-3 correcting stages follow. Within a stage, a digit gets a correction cell only if the value formed so far can push that digit to 5 or above. Everywhere else the digit is passed straight through. The output is not padded to whole nibbles. The leading digit has only as many bits as the largest leading digit that 2^N-1 can produce.

Top module: `bin2bcd_comb`

## Requirements
- R1: The output is a pure combinational function of the input and follows an input change with no clock edge.
- R2: For every input value, each 4-bit group of the output equals the matching decimal digit of that value, as given by repeated division and modulo by 10.
- R3: For N of 3 or less, the output equals the input bit for bit.
- R4: The output width is 4*(D-1) plus the bit width of the largest leading digit, where D is the decimal digit count of 2^N-1. So N=6 gives 7 bits, N=7 gives 9, N=9 gives 11, N=10 gives 13, N=12 gives 15 and N=24 gives 29.
- R5: Digits are packed least significant first: bits [3:0] hold the units, bits [7:4] the tens, and so on, with the shortened leading digit in the top bits.
- R6: No full 4-bit digit group of the output ever exceeds 9.
- R7: The correction cell maps a digit d in 0..9 to d+3 when d is 5 or more and to d otherwise, so its output never lies in 5..7.
- R8: With N=24, the output is correct for 0, for 16777215 (giving 29'h16777215) and for random values across the full range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | N | Unsigned binary value to convert |
| bcd_o | output | out_w(N) | Packed BCD result, units digit in the low nibble |

## Verification
Every input value is applied to converters with N of 1, 3, 6, 7, 9, 10 and 12. This covers the widths where no cell exists, where the first cell appears, and where the leading digit shrinks or a new digit group is added. Any wrong pruning decision at these points shows up as a wrong digit. For N=24, the bench applies zero, the all-ones value and random words, which catches faults that only show in the deep stages near the top digits. A single known value checks the digit packing order, and a mid-cycle check after an input change confirms that no clock is involved. The correction cell is also tried alone on all ten legal digits.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  function automatic longint unsigned pow10(input int d);
    longint unsigned p;
    p = 64'd1;
    for (int i = 0; i < d; i++) p = p * 64'd10;
    return p;
  endfunction

  function automatic longint unsigned max_val(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  // decimal digits needed for 2^n - 1
  function automatic int dig_count(input int n);
    longint unsigned v;
    int c;
    v = max_val(n);
    c = 1;
    while (v >= 64'd10) begin
      v = v / 64'd10;
      c++;
    end
    return c;
  endfunction

  // bits needed by the largest possible leading digit
  function automatic int top_w(input int n);
    longint unsigned t;
    int w;
    t = max_val(n) / pow10(dig_count(n) - 1);
    w = 0;
    while ((t >> w) != 64'd0) w++;
    return w;
  endfunction

  function automatic int out_w(input int n);
    return 4 * (dig_count(n) - 1) + top_w(n);
  endfunction

  // digit d can hold 5 or more once s bits have been shifted in
  function automatic bit need_fix(input int s, input int d);
    return max_val(s) >= 64'd5 * pow10(d);
  endfunction

endpackage

// File: rtl/bcd_adj_cell.sv
module bcd_adj_cell (
  input  logic [3:0] digit_i,
  output logic [3:0] digit_o
);

  assign digit_o = (digit_i >= 4'd5) ? (digit_i + 4'd3) : digit_i;

  always_comb begin
    if (!$isunknown(digit_i)) begin
      AST_CELL_IN_BCD: assert (digit_i <= 4'd9)
        else $error("cell input %0d is not a decimal digit", digit_i); // R6
      AST_CELL_OUT_GAP: assert (!(digit_o inside {4'd5, 4'd6, 4'd7}))
        else $error("cell output %0d in gap", digit_o); // R7
    end
  end

endmodule

// File: rtl/bcd_dabble_stage.sv
module bcd_dabble_stage
  import bcd_conv_pkg::*;
#(
  parameter int N = 24,
  parameter int S = 3,
  localparam int OW = out_w(N),
  localparam int D  = dig_count(N)
) (
  input  logic [OW-1:0] cur_i,
  input  logic          bit_i,
  output logic [OW-1:0] nxt_o
);

  logic [OW-1:0] adj;

  // full digit groups: cell only where a 5 is reachable at this stage
  for (genvar d = 0; d < D - 1; d++) begin : g_dig
    if (need_fix(S, d)) begin : g_cell
      bcd_adj_cell u_cell (
        .digit_i (cur_i[4*d +: 4]),
        .digit_o (adj[4*d +: 4])
      );
    end else begin : g_pass
      assign adj[4*d +: 4] = cur_i[4*d +: 4];
    end
  end

  // leading digit never reaches 5 before the last shift
  assign adj[OW-1:4*(D-1)] = cur_i[OW-1:4*(D-1)];

  assign nxt_o = {adj[OW-2:0], bit_i};

  always_comb begin
    if (!$isunknown(adj)) begin
      AST_NO_LOST_BIT: assert (adj[OW-1] == 1'b0)
        else $error("stage %0d shifts out a set bit", S); // R2
    end
  end

endmodule

// File: rtl/bin2bcd_comb.sv
module bin2bcd_comb
  import bcd_conv_pkg::*;
#(
  parameter int N = 24,
  localparam int OW = out_w(N),
  localparam int D  = dig_count(N)
) (
  input  logic [N-1:0]  bin_i,
  output logic [OW-1:0] bcd_o
);

  if (N <= 3) begin : g_direct
    assign bcd_o = bin_i;
  end else begin : g_chain
    logic [OW-1:0] chain [0:N-3];

    assign chain[0] = {{(OW-3){1'b0}}, bin_i[N-1:N-3]};

    for (genvar k = 0; k < N - 3; k++) begin : g_stage
      bcd_dabble_stage #(
        .N (N),
        .S (k + 3)
      ) u_stage (
        .cur_i (chain[k]),
        .bit_i (bin_i[N-4-k]),
        .nxt_o (chain[k+1])
      );
    end

    assign bcd_o = chain[N-3];
  end

  if (D > 1) begin : g_range_chk
    always_comb begin
      if (!$isunknown(bcd_o)) begin
        for (int d = 0; d < D - 1; d++) begin
          AST_DIGIT_RANGE: assert (bcd_o[4*d +: 4] <= 4'd9)
            else $error("digit %0d out of range", d); // R6
        end
      end
    end
  end

endmodule

// File: tb/bin2bcd_comb_tb.sv
module bin2bcd_comb_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic [23:0] stim;
  logic [3:0]  cell_in;
  logic [3:0]  cell_out;

  logic [0:0]  o1;
  logic [2:0]  o3;
  logic [6:0]  o6;
  logic [8:0]  o7;
  logic [10:0] o9;
  logic [12:0] o10;
  logic [14:0] o12;
  logic [28:0] o24;

  int n_chk;
  int n_fail;
  longint unsigned q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  bin2bcd_comb #(.N(24)) u_dut   (.bin_i(stim),        .bcd_o(o24));
  bin2bcd_comb #(.N(1))  u_dut1  (.bin_i(stim[0:0]),   .bcd_o(o1));
  bin2bcd_comb #(.N(3))  u_dut3  (.bin_i(stim[2:0]),   .bcd_o(o3));
  bin2bcd_comb #(.N(6))  u_dut6  (.bin_i(stim[5:0]),   .bcd_o(o6));
  bin2bcd_comb #(.N(7))  u_dut7  (.bin_i(stim[6:0]),   .bcd_o(o7));
  bin2bcd_comb #(.N(9))  u_dut9  (.bin_i(stim[8:0]),   .bcd_o(o9));
  bin2bcd_comb #(.N(10)) u_dut10 (.bin_i(stim[9:0]),   .bcd_o(o10));
  bin2bcd_comb #(.N(12)) u_dut12 (.bin_i(stim[11:0]),  .bcd_o(o12));
  bcd_adj_cell           u_cell  (.digit_i(cell_in),   .digit_o(cell_out));

  function automatic longint unsigned ref_bcd(input longint unsigned v);
    longint unsigned r;
    longint unsigned x;
    r = 0;
    x = v;
    for (int d = 0; d < 16; d++) begin
      r = r | ((x % 10) << (4 * d));
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input longint unsigned act,
                     input longint unsigned exp, input longint unsigned v);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s in=%0d actual=%h expected=%h", tag, v, act, exp);
    end
  endtask

  function automatic bit nibbles_ok(input longint unsigned b, input int full);
    bit ok;
    ok = 1'b1;
    for (int d = 0; d < full; d++)
      if (((b >> (4 * d)) & 64'hF) > 9) ok = 1'b0;
    return ok;
  endfunction

  task automatic drive(input longint unsigned v);
    @(posedge clk);
    stim <= v[23:0];
    q.push_back(v);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: pop expected stimulus and compare every converter
  always @(negedge clk) begin
    if (q.size() != 0) begin
      longint unsigned v;
      v = q.pop_front();
      chk("R3 N=1",  o1,  v % 2, v);
      chk("R3 N=3",  o3,  v % 8, v);
      chk("R2 N=6",  o6,  ref_bcd(v % 64), v);
      chk("R2 N=7",  o7,  ref_bcd(v % 128), v);
      chk("R2 N=9",  o9,  ref_bcd(v % 512), v);
      chk("R2 N=10", o10, ref_bcd(v % 1024), v);
      chk("R2 N=12", o12, ref_bcd(v % 4096), v);
      chk("R8 N=24", o24, ref_bcd(v % 16777216), v);
      chk("R6 N=12", nibbles_ok(o12, 3), 1, v);
      chk("R6 N=24", nibbles_ok(o24, 7), 1, v);
    end
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    stim   = '0;
    cell_in = '0;

    // R4: output widths
    chk("R4 N=6",  $bits(u_dut6.bcd_o),  7,  6);
    chk("R4 N=7",  $bits(u_dut7.bcd_o),  9,  7);
    chk("R4 N=9",  $bits(u_dut9.bcd_o),  11, 9);
    chk("R4 N=10", $bits(u_dut10.bcd_o), 13, 10);
    chk("R4 N=12", $bits(u_dut12.bcd_o), 15, 12);
    chk("R4 N=24", $bits(u_dut.bcd_o),   29, 24);

    // R7: correction cell on every legal digit
    for (int d = 0; d < 10; d++) begin
      cell_in = 4'(d);
      #1;
      chk("R7 cell", cell_out, (d >= 5) ? d + 3 : d, d);
    end

    // exhaustive small values, then N=24 corners and random words
    for (int v = 0; v < 4096; v++) drive(v);
    drive(0);
    drive(24'hFFFFFF);
    for (int i = 0; i < 300; i++) drive({8'h0, $urandom} & 64'hFFFFFF);
    repeat (3) @(posedge clk);

    // R5: packing order of a known value
    @(negedge clk);
    stim = 24'd1234;
    #1;
    chk("R5 N=12", o12, 64'h1234, 1234);

    // R8: all-ones corner written out
    stim = 24'hFFFFFF;
    #1;
    chk("R8 N=24", o24, 64'h16777215, 16777215);

    // R1: output follows the input mid-cycle, no edge involved
    stim = 24'd9876543;
    #1;
    chk("R1 N=24", o24, 64'h9876543, 9876543);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

endmodule